// File: doc/BRIEF.md
# Gatable Monostable/Astable Pulse Timer

This block replaces a resistor-capacitor multivibrator with counters driven by a system clock. It has two jobs. In the free-running job it makes a gated square wave on a pair of complementary outputs, plus a tap that runs at double rate. In the one-shot job it turns a rising or falling trigger edge into a pulse of fixed length. That pulse can be stretched by retrigger edges. A master reset clears any pulse or oscillation at once.

The square-wave half period and the one-shot width are parameters counted in clock cycles. Their defaults follow the 4.40 : 2.48 ratio of square-wave period to pulse width that the RC part has. The double-rate tap has half the square-wave period. The five control inputs (both triggers, retrigger and both run enables) are asynchronous. Each passes through a two-flop synchronizer before use, so an input applied just before a clock edge shows at the outputs after the third rising edge. The master reset acts on the outputs straight away, with no clock, and also clears the internal state at the next edge. `HALF_CYC` must be even and at least 4, and `PULSE_CYC` must be at least 2.

Top module: `pulse_timer`

## Requirements
- R1: While `rst_n` is low, and after it is released with every input idle (`astb_en`=0, `astb_en_n`=1, triggers, retrigger and `mreset` low), `q`=0, `q_n`=1 and `osc`=0.
- R2: The timer runs while `astb_en` is 1 or `astb_en_n` is 0. An enable applied before a rising edge raises `q` after the third rising edge. `q` then alternates between HALF_CYC cycles high and HALF_CYC cycles low.
- R3: While running, `osc` is high for the first HALF_CYC/2 cycles of every half period of `q` and low for the rest, so it rises twice per `q` period. While stopped it is 0.
- R4: When the run condition goes away, a high half period of `q` always runs its full HALF_CYC cycles. After the following low half period, `q` and `osc` stay low.
- R5: A rising edge on `trig_pos` while `trig_neg` is low starts a pulse. `q` rises after the third clock edge and stays high for exactly PULSE_CYC cycles. A rising edge on `trig_pos` while `trig_neg` is high starts nothing.
- R6: A falling edge on `trig_neg` while `trig_pos` is high starts the same pulse. A falling edge on `trig_neg` while `trig_pos` is low starts nothing.
- R7: The pulse width is PULSE_CYC whatever the trigger's own length, including a trigger held high for longer than the pulse.
- R8: A trigger edge that arrives during a pulse has no effect on the pulse length.
- R9: A rising edge on `retrig` during a pulse restarts the count. With `retrig` driven together with `trig_pos` at a period shorter than PULSE_CYC, `q` stays high without a gap and falls PULSE_CYC cycles after the last edge takes effect.
- R10: A falling edge on `retrig` during a pulse has no effect on its length.
- R11: While `mreset` is 1, `q`=0 and `osc`=0 without waiting for a clock edge. Any pulse or oscillation in progress is cleared. Trigger edges and run enables are overridden.
- R12: `q_n` is always the inverse of `q`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trig_pos | input | 1 | Rising-edge trigger |
| trig_neg | input | 1 | Falling-edge trigger |
| astb_en | input | 1 | Run enable, active high |
| astb_en_n | input | 1 | Run enable, active low |
| retrig | input | 1 | Retrigger, acts on its rising edge |
| mreset | input | 1 | Master reset, active high |
| q | output | 1 | Square wave or one-shot pulse |
| q_n | output | 1 | Inverse of q |
| osc | output | 1 | Double-rate oscillator tap |

## Verification
The free-running job is driven twice: once through the active-high enable and once through the active-low enable. This shows that both gate the same counter, and the stop test shows that a high half period is never cut short. The one-shot job is tried with the following, each measured against PULSE_CYC:
- a short positive trigger;
- a falling negative trigger;
- a trigger held longer than the pulse;
- a second edge during the pulse;
- a train of retrigger edges;
- a retrigger that falls during the pulse.

The trigger tests separate width-from-start behaviour from width-from-last-edge behaviour. Edges with the other trigger at the wrong level, and edges under master reset, must leave `q` low. A behavioural model runs beside the design and compares all three outputs on every clock.

// File: rtl/pt_pkg.sv
package pt_pkg;
  typedef struct packed {
    logic retrig;
    logic trig_neg;
    logic trig_pos;
    logic en_n;
    logic en;
  } pt_in_t;

  localparam int PT_IN_W = 5;
  // Idle level of every control input; the low-active enable idles high.
  localparam logic [PT_IN_W-1:0] PT_IN_IDLE = 5'b00010;
endpackage

// File: rtl/pt_sync.sv
module pt_sync #(
  parameter int W = 1,
  parameter logic [W-1:0] RST = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;

  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q[i] <= RST[i];
        q[i]      <= RST[i];
      end else begin
        meta_q[i] <= d[i];
        q[i]      <= meta_q[i];
      end
    end
  end
endmodule

// File: rtl/pt_trig_decode.sv
module pt_trig_decode (
  input  logic clk,
  input  logic rst_n,
  input  logic tp_s,
  input  logic tn_s,
  input  logic rt_s,
  output logic fire,
  output logic rearm
);
  logic tp_prev_q, tn_prev_q, rt_prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tp_prev_q <= 1'b0;
      tn_prev_q <= 1'b0;
      rt_prev_q <= 1'b0;
    end else begin
      tp_prev_q <= tp_s;
      tn_prev_q <= tn_s;
      rt_prev_q <= rt_s;
    end
  end

  // rising positive trigger gated by low negative trigger, or
  // falling negative trigger gated by high positive trigger
  assign fire  = (tp_s & ~tp_prev_q & ~tn_s) | (~tn_s & tn_prev_q & tp_s);
  assign rearm = rt_s & ~rt_prev_q;
endmodule

// File: rtl/pt_astable.sv
module pt_astable #(
  parameter int HALF_CYC = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mr,
  input  logic run,
  output logic q_o,
  output logic osc_o
);
  localparam int CW  = (HALF_CYC > 2) ? $clog2(HALF_CYC) : 1;
  localparam int QTR = HALF_CYC / 2;
  localparam logic [CW-1:0] LAST = CW'(HALF_CYC - 1);

  logic          on_q, on_d;
  logic          ph_q, ph_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  assign cnt_en = on_q & (cnt_q != LAST);

  always_comb begin
    on_d  = on_q;
    ph_d  = ph_q;
    cnt_d = cnt_q;
    if (mr) begin
      on_d  = 1'b0;
      ph_d  = 1'b0;
      cnt_d = '0;
    end else if (!on_q) begin
      if (run) begin
        on_d  = 1'b1;
        ph_d  = 1'b1;
        cnt_d = '0;
      end
    end else if (cnt_en) begin
      cnt_d = cnt_q + 1'b1;
    end else begin
      cnt_d = '0;
      if (ph_q)     ph_d = 1'b0;
      else if (run) ph_d = 1'b1;
      else          on_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      on_q  <= 1'b0;
      ph_q  <= 1'b0;
      cnt_q <= '0;
    end else begin
      on_q  <= on_d;
      ph_q  <= ph_d;
      cnt_q <= cnt_d;
    end
  end

  assign q_o   = ph_q;
  assign osc_o = on_q & (cnt_q < CW'(QTR));

  // R4: a high half period ends only at its last count
  p_full_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(ph_q) && !$past(mr)) |-> ($past(cnt_q) == LAST));

  // R11: master reset stops the oscillator at the next edge
  p_mr_stops_r11: assert property (@(posedge clk) disable iff (!rst_n)
    mr |=> (!on_q && !ph_q));
endmodule

// File: rtl/pt_oneshot.sv
module pt_oneshot #(
  parameter int PULSE_CYC = 11
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mr,
  input  logic fire,
  input  logic rearm,
  output logic q_o
);
  localparam int CW = (PULSE_CYC > 2) ? $clog2(PULSE_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(PULSE_CYC - 1);

  logic          busy_q, busy_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    if (mr) begin
      busy_d = 1'b0;
      cnt_d  = '0;
    end else if (!busy_q) begin
      if (fire) begin
        busy_d = 1'b1;
        cnt_d  = '0;
      end
    end else if (rearm) begin
      cnt_d = '0;
    end else if (cnt_q == LAST) begin
      busy_d = 1'b0;
      cnt_d  = '0;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
    end
  end

  assign q_o = busy_q;

  // R5: a pulse is not cut short before its last count
  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !mr && !rearm && cnt_q != LAST) |=> busy_q);

  // R8: a pulse begins only from an idle state on a decoded trigger
  p_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> $past(fire));

  // R9: a retrigger edge during a pulse restarts the count
  p_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && rearm && !mr) |=> (busy_q && cnt_q == '0));

  // R11: master reset ends the pulse at the next edge
  p_mr_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
    mr |=> !busy_q);
endmodule

// File: rtl/pulse_timer.sv
module pulse_timer #(
  parameter int HALF_CYC  = 10,
  parameter int PULSE_CYC = 11
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trig_pos,
  input  logic trig_neg,
  input  logic astb_en,
  input  logic astb_en_n,
  input  logic retrig,
  input  logic mreset,
  output logic q,
  output logic q_n,
  output logic osc
);
  import pt_pkg::*;

  pt_in_t raw_in, syn_in;
  logic   run, fire, rearm;
  logic   ast_q, ast_osc, shot_q;

  always_comb begin
    raw_in.retrig   = retrig;
    raw_in.trig_neg = trig_neg;
    raw_in.trig_pos = trig_pos;
    raw_in.en_n     = astb_en_n;
    raw_in.en       = astb_en;
  end

  pt_sync #(.W(PT_IN_W), .RST(PT_IN_IDLE)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw_in), .q(syn_in)
  );

  assign run = syn_in.en | ~syn_in.en_n;

  pt_trig_decode u_decode (
    .clk(clk), .rst_n(rst_n),
    .tp_s(syn_in.trig_pos), .tn_s(syn_in.trig_neg), .rt_s(syn_in.retrig),
    .fire(fire), .rearm(rearm)
  );

  pt_astable #(.HALF_CYC(HALF_CYC)) u_astable (
    .clk(clk), .rst_n(rst_n), .mr(mreset), .run(run),
    .q_o(ast_q), .osc_o(ast_osc)
  );

  pt_oneshot #(.PULSE_CYC(PULSE_CYC)) u_oneshot (
    .clk(clk), .rst_n(rst_n), .mr(mreset), .fire(fire), .rearm(rearm),
    .q_o(shot_q)
  );

  assign q   = (ast_q | shot_q) & ~mreset;
  assign q_n = ~q;
  assign osc = ast_osc & ~mreset;

  // R11: master reset overrides every source, combinationally
  always_comb begin
    if (rst_n && mreset) a_mr_out_r11: assert (!q && !osc);
  end
endmodule

// File: tb/pulse_timer_bench.sv
module pulse_timer_bench;
  localparam int CLK_PERIOD = 10;
  localparam int H  = 10;
  localparam int P  = 11;
  localparam int QT = H / 2;

  logic clk = 1'b0;
  logic rst_n;
  logic tp, tn, en, en_n, rt, mreset;
  logic q, q_n, osc;

  int total = 0;
  int bad   = 0;
  bit done  = 0;
  string tag = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;

  pulse_timer #(.HALF_CYC(H), .PULSE_CYC(P)) u_pulse_timer (
    .clk(clk), .rst_n(rst_n), .trig_pos(tp), .trig_neg(tn),
    .astb_en(en), .astb_en_n(en_n), .retrig(rt), .mreset(mreset),
    .q(q), .q_n(q_n), .osc(osc)
  );

  task automatic chk(input string r, input string what, input int got, input int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s %s: got %0d expected %0d", r, what, got, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  logic [4:0] m_d1, m_d2, m_pv;
  int  a_on, a_q, a_cnt, m_busy, m_cnt;
  bit  m_run, m_fire, m_re;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_d1 = 5'b00010; m_d2 = 5'b00010; m_pv = 5'b00010;
      a_on = 0; a_q = 0; a_cnt = 0; m_busy = 0; m_cnt = 0;
    end else begin
      m_run  = m_d2[0] | ~m_d2[1];
      m_fire = (m_d2[2] & ~m_pv[2] & ~m_d2[3]) | (~m_d2[3] & m_pv[3] & m_d2[2]);
      m_re   = m_d2[4] & ~m_pv[4];
      if (mreset) begin
        a_on = 0; a_q = 0; a_cnt = 0; m_busy = 0; m_cnt = 0;
      end else begin
        if (a_on == 0) begin
          if (m_run) begin a_on = 1; a_q = 1; a_cnt = 0; end
        end else if (a_cnt == H - 1) begin
          a_cnt = 0;
          if (a_q == 1) a_q = 0;
          else if (m_run) a_q = 1;
          else a_on = 0;
        end else a_cnt++;
        if (m_busy == 0) begin
          if (m_fire) begin m_busy = 1; m_cnt = 0; end
        end else if (m_re) m_cnt = 0;
        else if (m_cnt == P - 1) begin m_busy = 0; m_cnt = 0; end
        else m_cnt++;
      end
      m_pv = m_d2; m_d2 = m_d1; m_d1 = {rt, tn, tp, en_n, en};
    end
  end

  always @(posedge clk) begin
    #(CLK_PERIOD/4);
    if (rst_n && !done) begin
      int eq, eo;
      eq = (((a_on != 0) && (a_q != 0)) || (m_busy != 0)) && !mreset;
      eo = (a_on != 0) && (a_cnt < QT) && !mreset;
      chk(tag, "model q", q, eq);
      chk("R12", "model q_n", q_n, !eq);
      chk(tag, "model osc", osc, eo);
    end
  end

  // ---------------- helpers ----------------
  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wait_q(input logic v);
    for (int i = 0; i < 200 && q !== v; i++) @(negedge clk);
  endtask

  task automatic len_q(output int w);
    logic v;
    v = q; w = 0;
    while (q === v && w < 500) begin w++; @(negedge clk); end
  endtask

  task automatic stays_low(input string r, input int n);
    int hi;
    hi = 0;
    for (int i = 0; i < n; i++) begin @(negedge clk); if (q !== 1'b0) hi++; end
    chk(r, "q high samples", hi, 0);
  endtask

  task automatic pulse_tp(input int hi);
    tp = 1; tick(hi); tp = 0;
  endtask

  // ---------------- watchdog ----------------
  initial begin
    for (int i = 0; i < 100000; i++) @(posedge clk);
    if (!done) begin
      done = 1; bad++; total++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  initial begin
    int w, rises;
    logic pv;
    rst_n = 0; tp = 0; tn = 0; en = 0; en_n = 1; rt = 0; mreset = 0;
    tick(4);
    chk("R1", "reset q", q, 0); chk("R1", "reset q_n", q_n, 1); chk("R1", "reset osc", osc, 0);
    rst_n = 1;
    tick(5);
    chk("R1", "idle q", q, 0); chk("R1", "idle osc", osc, 0);

    // R2 true enable
    tag = "R2";
    en = 1;
    tick(2); chk("R2", "q before 3rd edge", q, 0);
    tick(1); chk("R2", "q after 3rd edge", q, 1);
    len_q(w); chk("R2", "high half", w, H);
    len_q(w); chk("R2", "low half", w, H);
    chk("R12", "q_n inverse", q_n, !q);

    // R3 oscillator tap, now at the start of a high half
    tag = "R3";
    rises = 0; pv = osc;
    for (int i = 0; i < 2 * H; i++) begin
      @(negedge clk);
      if (osc === 1'b1 && pv === 1'b0) rises++;
      pv = osc;
    end
    chk("R3", "osc rises per q period", rises, 2);
    for (int i = 0; i < 40 && osc !== 1'b0; i++) @(negedge clk);
    for (int i = 0; i < 40 && osc !== 1'b1; i++) @(negedge clk);
    w = 0;
    while (osc === 1'b1 && w < 100) begin w++; @(negedge clk); end
    chk("R3", "osc high length", w, QT);

    // R4 stop without runt
    tag = "R4";
    wait_q(0); wait_q(1);
    en = 0;
    len_q(w); chk("R4", "last high half", w, H);
    tick(H + 2);
    stays_low("R4", 3 * H);
    chk("R4", "osc after stop", osc, 0);

    // R2 complement enable
    tag = "R2";
    en_n = 0;
    tick(3); chk("R2", "q via low enable", q, 1);
    len_q(w); chk("R2", "high half low enable", w, H);
    en_n = 1;
    tick(3 * H);
    chk("R2", "stopped", q, 0);

    // R5 positive trigger
    tag = "R5";
    tp = 1; tick(2); chk("R5", "q before 3rd edge", q, 0);
    tick(1); chk("R5", "q after 3rd edge", q, 1);
    tp = 0;
    len_q(w); chk("R5", "width", w, P - 3 + 3);
    tick(5);
    tn = 1; tick(4); pulse_tp(2); tick(1); tn = 0;
    stays_low("R5", 20);

    // R6 negative trigger
    tag = "R6";
    tp = 1; tn = 1; tick(5); tn = 0;
    wait_q(1); len_q(w); chk("R6", "width", w, P);
    tp = 0; tick(4);
    tn = 1; tick(4); tn = 0;
    stays_low("R6", 20);

    // R7 long trigger
    tag = "R7";
    tp = 1;
    wait_q(1); len_q(w); chk("R7", "width with long trigger", w, P);
    tick(10); tp = 0; tick(5);
    chk("R7", "no second pulse", q, 0);

    // R8 second edge during pulse ignored
    tag = "R8";
    fork
      begin pulse_tp(2); tick(3); pulse_tp(2); end
      begin wait_q(1); len_q(w); end
    join
    chk("R8", "width with extra edge", w, P);
    tick(5);

    // R9 retrigger train
    tag = "R9";
    fork
      begin
        for (int k = 0; k < 4; k++) begin
          tp = 1; rt = 1; tick(2); tp = 0; rt = 0; tick(4);
        end
      end
      begin wait_q(1); len_q(w); end
    join
    chk("R9", "stretched width", w, 18 + P);
    tick(5);

    // R10 retrigger falling edge ignored
    tag = "R10";
    rt = 1; tick(5);
    fork
      begin pulse_tp(2); tick(2); rt = 0; end
      begin wait_q(1); len_q(w); end
    join
    chk("R10", "width with falling retrigger", w, P);
    tick(5);

    // R11 master reset
    tag = "R11";
    pulse_tp(2); wait_q(1); tick(3);
    mreset = 1; #1;
    chk("R11", "q immediate", q, 0); chk("R11", "q_n immediate", q_n, 1);
    tick(1); mreset = 0; tick(3);
    chk("R11", "pulse cleared", q, 0);
    mreset = 1; pulse_tp(2); tick(6); mreset = 0;
    stays_low("R11", 15);
    mreset = 1; en = 1; tick(10);
    chk("R11", "osc held", osc, 0); chk("R11", "q held", q, 0);
    mreset = 0;
    tick(2); chk("R11", "restart after release", q, 1);
    en = 0; tick(3 * H);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule